// File: doc/BRIEF.md
# Base-delta cache line decompressor

This block rebuilds a 32-byte cache line from its compressed form in one pass. A compressed line is carried as a payload word and a small encoding code. The code names the form the line was stored in. A line may be stored raw, as all zeros, or as one repeated 64-bit value. It may also be stored as a shared base plus one narrow delta per element. Each base/delta format fixes the element width and the delta width.

For base/delta formats, every element is rebuilt at the same time. The block sign-extends the element's delta to the element width. It then adds either the shared base or an implicit base of zero, as chosen by that element's mask bit. No element depends on another, so decoding is a flat vector addition and not a serial walk.

Data enters and leaves on valid/ready handshakes. A transfer takes place on any clock edge where valid and ready are both high. With the output register enabled, a result is held unchanged while the consumer holds `out_ready` low. During that stall the input sees `in_ready` low, unless the register is empty or is being drained in the same cycle. Without the register the block is purely combinational. In that case back-pressure passes straight through: `in_ready` follows `out_ready`, and `out_valid` follows `in_valid`.

Top module: `bdi_line_decomp`

## Requirements
- R1: Code 0 (raw) drives the 256-bit payload unchanged onto `out_line`.
- R2: Code 1 (zero line) drives all 256 bits of `out_line` to zero, whatever the payload holds.
- R3: Code 2 (repeated value) copies payload bits [63:0] into each of the four 64-bit slots of `out_line`.
- R4: Codes 3, 4 and 5 describe a line of four 8-byte elements with 1-, 2- and 4-byte deltas respectively.
  - The 64-bit base sits at payload bits [63:0].
  - Delta i (width DW bits) starts at bit 64+i*DW.
  - Mask bit i sits at bit 64+4*DW+i.
  - Element i appears at `out_line` bits [64i+63:64i].
- R5: Codes 6 and 7 describe a line of eight 4-byte elements with 1- and 2-byte deltas, using the same layout rules as R4.
  - The 32-bit base sits at payload bits [31:0].
  - Delta i starts at bit 32+i*DW.
  - Mask bit i sits at bit 32+8*DW+i.
  - Element i appears at `out_line` bits [32i+31:32i].
- R6: Code 8 describes a line of sixteen 2-byte elements with 1-byte deltas.
  - The 16-bit base sits at bits [15:0].
  - Delta i sits at bits [16+8i+7:16+8i].
  - Mask bit i sits at bit 144+i.
- R7: Each delta is sign-extended to the element width, and the sum with the base wraps modulo 2 to the power of the element width.
- R8: A mask bit of 1 adds the shared base to that element's delta. A mask bit of 0 adds zero, so the element equals the sign-extended delta.
- R9: Codes 9 to 15 are reserved and are treated as raw (payload passed through).
- R10: With `REG_OUT`=1:
  - An accepted input appears on `out_line` with `out_valid` high one clock later.
  - While `out_valid` is high and `out_ready` is low, `out_line` and `out_valid` hold and no new input is accepted.
  - `in_ready` is high whenever the register is empty or is being drained.
- R11: With `REG_OUT`=0, `out_line` is a combinational function of the current inputs, `out_valid` equals `in_valid`, and `in_ready` equals `out_ready`.
- R12: While `rst_n` is low, `out_valid` is low in the registered build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Compressed line offered |
| in_ready | output | 1 | Block can take the offered line |
| in_enc | input | 4 | Encoding code (see R1 to R9) |
| in_payload | input | 256 | Compressed payload, packed from bit 0 upward |
| out_valid | output | 1 | Rebuilt line available |
| out_ready | input | 1 | Consumer takes the rebuilt line |
| out_line | output | 256 | Rebuilt 32-byte line |

## Verification
The bench builds two copies of the block with the default 32-byte line. Both copies see the same input stream.
- The first copy has the output register enabled. It brings the one-cycle latency and the hold-under-stall behaviour within reach.
- The second copy has the output register removed. Its line can be compared in the same cycle, which exposes the direct pass-through of valid and ready.

Between them, the two copies cover:
- all nine defined codes and a reserved code;
- wrapping sums and negative deltas;
- a mixed mask that sends some elements to the zero base.

// File: rtl/bdi_pkg.sv
package bdi_pkg;
  localparam int ENC_W   = 4;
  localparam int NUM_FMT = 6;

  typedef enum logic [ENC_W-1:0] {
    ENC_RAW  = 4'd0,
    ENC_ZERO = 4'd1,
    ENC_REP  = 4'd2,
    ENC_B8D1 = 4'd3,
    ENC_B8D2 = 4'd4,
    ENC_B8D4 = 4'd5,
    ENC_B4D1 = 4'd6,
    ENC_B4D2 = 4'd7,
    ENC_B2D1 = 4'd8
  } bdi_enc_e;

  // Base width in bytes of base/delta format g (g = code - 3).
  function automatic int fmt_base_bytes(input int g);
    case (g)
      0, 1, 2: return 8;
      3, 4:    return 4;
      default: return 2;
    endcase
  endfunction

  // Delta width in bytes of base/delta format g.
  function automatic int fmt_delta_bytes(input int g);
    case (g)
      0, 3, 5: return 1;
      1, 4:    return 2;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/bdi_lane_expand.sv
module bdi_lane_expand #(
  parameter  int LINE_BYTES = 32,
  parameter  int BASE_B     = 8,
  parameter  int DELTA_B    = 1,
  localparam int LINE_W     = LINE_BYTES * 8,
  localparam int BW         = BASE_B * 8,
  localparam int DW         = DELTA_B * 8,
  localparam int NELEM      = LINE_BYTES / BASE_B,
  localparam int USED_W     = BW + NELEM * DW + NELEM
) (
  input  logic [USED_W-1:0] pkt,
  output logic [LINE_W-1:0] line
);
  localparam int MASK_LO = BW + NELEM * DW;

  logic [BW-1:0] base;
  assign base = pkt[BW-1:0];

  for (genvar i = 0; i < NELEM; i++) begin : g_elem
    logic [DW-1:0] dlt;
    logic [BW-1:0] dext;
    logic [BW-1:0] addend;
    assign dlt    = pkt[BW + i*DW +: DW];
    if (BW > DW) begin : g_sx
      assign dext = {{(BW-DW){dlt[DW-1]}}, dlt};
    end else begin : g_nosx
      assign dext = dlt;
    end
    assign addend = pkt[MASK_LO + i] ? base : '0;
    assign line[i*BW +: BW] = addend + dext;
  end
endmodule

// File: rtl/bdi_fmt_select.sv
module bdi_fmt_select
  import bdi_pkg::*;
#(
  parameter  int LINE_BYTES = 32,
  localparam int LINE_W     = LINE_BYTES * 8
) (
  input  logic [ENC_W-1:0]  enc,
  input  logic [LINE_W-1:0] payload,
  output logic [LINE_W-1:0] line
);
  logic [LINE_W-1:0] fmt_line [NUM_FMT];

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    localparam int BB = fmt_base_bytes(g);
    localparam int DB = fmt_delta_bytes(g);
    localparam int NE = LINE_BYTES / BB;
    localparam int UW = BB*8 + NE*DB*8 + NE;
    bdi_lane_expand #(
      .LINE_BYTES (LINE_BYTES),
      .BASE_B     (BB),
      .DELTA_B    (DB)
    ) u_lane (
      .pkt  (payload[UW-1:0]),
      .line (fmt_line[g])
    );
  end

  always_comb begin
    case (enc)
      ENC_ZERO: line = '0;
      ENC_REP:  line = {(LINE_W/64){payload[63:0]}};
      ENC_B8D1: line = fmt_line[0];
      ENC_B8D2: line = fmt_line[1];
      ENC_B8D4: line = fmt_line[2];
      ENC_B4D1: line = fmt_line[3];
      ENC_B4D2: line = fmt_line[4];
      ENC_B2D1: line = fmt_line[5];
      default:  line = payload;
    endcase
  end
endmodule

// File: rtl/bdi_out_stage.sv
module bdi_out_stage #(
  parameter int W       = 256,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  if (REG_OUT) begin : g_reg
    logic         vld_q;
    logic [W-1:0] dat_q;
    assign in_ready = !vld_q || out_ready;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
      end else if (in_ready) begin
        vld_q <= in_valid;
      end
    end
    always_ff @(posedge clk) begin
      if (in_valid && in_ready) dat_q <= in_data;
    end
    assign out_valid = vld_q;
    assign out_data  = dat_q;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end
endmodule

// File: rtl/bdi_line_decomp.sv
module bdi_line_decomp
  import bdi_pkg::*;
#(
  parameter  int LINE_BYTES = 32,
  parameter  bit REG_OUT    = 1'b1,
  localparam int LINE_W     = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ENC_W-1:0]  in_enc,
  input  logic [LINE_W-1:0] in_payload,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LINE_W-1:0] out_line
);
  logic [LINE_W-1:0] dec_line;

  bdi_fmt_select #(.LINE_BYTES(LINE_BYTES)) u_sel (
    .enc     (in_enc),
    .payload (in_payload),
    .line    (dec_line)
  );

  bdi_out_stage #(.W(LINE_W), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (dec_line),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_line)
  );
endmodule

// File: rtl/bdi_decomp_chk.sv
module bdi_decomp_chk #(
  parameter int LINE_W  = 256,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [3:0]        in_enc,
  input logic [LINE_W-1:0] in_payload,
  input logic              out_valid,
  input logic              out_ready,
  input logic [LINE_W-1:0] out_line
);
  if (REG_OUT) begin : g_reg
    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_line)));
    // R10
    accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);
    // R2
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_enc == 4'd1) |=> (out_line == '0));
    // R1
    raw_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_enc == 4'd0) |=> (out_line == $past(in_payload)));
    // R12
    reset_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);
  end else begin : g_comb
    // R11
    pass_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid == in_valid) && (in_ready == out_ready));
    // R2
    zero_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_enc == 4'd1) |-> (out_line == '0));
    // R1
    raw_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_enc == 4'd0) |-> (out_line == in_payload));
  end
endmodule

bind bdi_line_decomp bdi_decomp_chk #(.LINE_W(LINE_W), .REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_enc     (in_enc),
  .in_payload (in_payload),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_line   (out_line)
);

// File: tb/tb_bdi_line_decomp.sv
module tb_bdi_line_decomp;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [3:0]   in_enc = 4'd0;
  logic [255:0] in_payload = '0;
  logic         rdy_r = 1'b1, rdy_c = 1'b1;
  logic         in_ready_r, in_ready_c, ov_r, ov_c;
  logic [255:0] line_r, line_c;
  int           n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  bdi_line_decomp #(.REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_r),
    .in_enc(in_enc), .in_payload(in_payload), .out_valid(ov_r),
    .out_ready(rdy_r), .out_line(line_r));

  bdi_line_decomp #(.REG_OUT(1'b0)) dut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_c),
    .in_enc(in_enc), .in_payload(in_payload), .out_valid(ov_c),
    .out_ready(rdy_c), .out_line(line_c));

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] fmask(input int bits);
    return (64'h1 << bits) - 64'h1;
  endfunction

  // Independent model of R4-R8.
  function automatic logic [255:0] model(input logic [3:0] e, input logic [255:0] p);
    int bb, db, n, bw, dw;
    logic [255:0] r = '0;
    logic [63:0] base, d, s;
    case (e)
      4'd3: begin bb = 8; db = 1; end
      4'd4: begin bb = 8; db = 2; end
      4'd5: begin bb = 8; db = 4; end
      4'd6: begin bb = 4; db = 1; end
      4'd7: begin bb = 4; db = 2; end
      default: begin bb = 2; db = 1; end
    endcase
    n = 32 / bb; bw = bb * 8; dw = db * 8;
    base = p[63:0] & fmask(bw);
    for (int i = 0; i < n; i++) begin
      d = 64'(p >> (bw + i*dw)) & fmask(dw);
      if (d[dw-1]) d = d | ~fmask(dw);
      s = (p[bw + n*dw + i] ? base : 64'h0) + d;
      s = s & fmask(bw);
      r = r | (256'(s) << (i*bw));
    end
    return r;
  endfunction

  task automatic send(input logic [3:0] e, input logic [255:0] p, input logic [255:0] exp, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_enc = e; in_payload = p;
    #1;
    check(ov_c && line_c == exp, {req, " comb"}, line_c, exp);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(ov_r && line_r == exp, {req, " reg"}, line_r, exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!ov_r, "R12 reset out_valid", 256'(ov_r), 256'h0);
  endtask

  task automatic t_raw();
    logic [255:0] p = {8{32'hA5C3_0F19}} ^ 256'h1234;
    send(4'd0, p, p, "R1 raw");
  endtask

  task automatic t_zero();
    send(4'd1, {8{32'hDEAD_BEEF}}, '0, "R2 zero");
  endtask

  task automatic t_repeat();
    logic [255:0] p = {192'hFFFF, 64'h0000_00FF_1122_3344};
    send(4'd2, p, {4{64'h0000_00FF_1122_3344}}, "R3 repeat");
  endtask

  task automatic t_base8();
    logic [255:0] p = '0, exp;
    // R4: base C04039C0, deltas 00 08 10 F8, mask 1111
    p[63:0] = 64'h0000_0000_C040_39C0;
    p[95:64] = 32'hF8_10_08_00;
    p[99:96] = 4'hF;
    exp = {64'h0000_0000_C040_39B8, 64'h0000_0000_C040_39D0,
           64'h0000_0000_C040_39C8, 64'h0000_0000_C040_39C0};
    send(4'd3, p, exp, "R4 b8d1");
    p = '0;
    p[63:0] = 64'h1000_0000_0000_0000;
    p[191:64] = {32'h8000_0000, 32'h0000_0010, 32'h7FFF_FFFF, 32'hFFFF_FFFF};
    p[195:192] = 4'hF;
    send(4'd5, p, model(4'd5, p), "R4 b8d4");
    p = '0;
    p[63:0] = 64'h0123_4567_89AB_CDEF;
    p[127:64] = 64'hFFFE_8000_0100_0002;
    p[131:128] = 4'b1011;
    send(4'd4, p, model(4'd4, p), "R4 b8d2");
  endtask

  task automatic t_base4();
    logic [255:0] p = '0;
    p[31:0] = 32'h0000_1000;
    p[95:32] = 64'h7F80_0102_FF00_05FB;
    p[103:96] = 8'hFF;
    send(4'd6, p, model(4'd6, p), "R5 b4d1");
    p = '0;
    p[31:0] = 32'hABCD_0000;
    p[159:32] = 128'h8000_7FFF_0001_FFFF_1234_0000_FEDC_0010;
    p[167:160] = 8'b1010_0111;
    send(4'd7, p, model(4'd7, p), "R5 b4d2");
  endtask

  task automatic t_base2();
    logic [255:0] p = '0;
    p[15:0] = 16'h4000;
    for (int i = 0; i < 16; i++) p[16 + 8*i +: 8] = 8'(i * 17 - 40);
    p[159:144] = 16'hF0F3;
    send(4'd8, p, model(4'd8, p), "R6 b2d1");
  endtask

  task automatic t_wrap();
    logic [255:0] p = '0, exp;
    // R7: base FFFFFFFF + 01 wraps to 0; + 80 gives FFFFFF7F
    p[31:0] = 32'hFFFF_FFFF;
    p[39:32] = 8'h01;
    p[47:40] = 8'h80;
    p[103:96] = 8'hFF;
    exp = {{6{32'hFFFF_FFFF}}, 32'hFFFF_FF7F, 32'h0000_0000};
    send(4'd6, p, exp, "R7 wrap");
  endtask

  task automatic t_zero_base();
    logic [255:0] p = '0, exp;
    // R8: mask 0 on elements 0 and 2: element = sign-extended delta
    p[63:0] = 64'h5555_0000_0000_0000;
    p[95:64] = 32'h03_02_80_01;
    p[99:96] = 4'b1010;
    exp = {64'h5555_0000_0000_0003, 64'hFFFF_FFFF_FFFF_FF80,
           64'h5555_0000_0000_0002, 64'h0000_0000_0000_0001};
    exp = {exp[255:192], 64'hFFFF_FFFF_FFFF_FF80 + 64'h0, exp[127:0]};
    exp[191:128] = 64'h0000_0000_0000_0002;
    exp[63:0]    = 64'h0000_0000_0000_0001;
    exp[127:64]  = 64'h5555_0000_0000_0000 + 64'hFFFF_FFFF_FFFF_FF80;
    exp[255:192] = 64'h5555_0000_0000_0003;
    send(4'd3, p, exp, "R8 zero base");
  endtask

  task automatic t_reserved();
    logic [255:0] p = {4{64'h0F1E_2D3C_4B5A_6978}};
    send(4'd11, p, p, "R9 reserved");
    send(4'd15, ~p, ~p, "R9 reserved");
  endtask

  task automatic t_stall();
    logic [255:0] a = {8{32'h1111_2222}}, b = {8{32'h3333_4444}};
    @(negedge clk);
    rdy_r = 1'b0; in_valid = 1'b1; in_enc = 4'd0; in_payload = a;
    @(posedge clk); @(negedge clk);
    check(ov_r && line_r == a, "R10 first out", line_r, a);
    in_payload = b;
    check(!in_ready_r, "R10 ready low in stall", 256'(in_ready_r), 256'h0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
      check(ov_r && line_r == a, "R10 hold", line_r, a);
    end
    rdy_r = 1'b1;
    #1;
    check(in_ready_r, "R10 ready on drain", 256'(in_ready_r), 256'h1);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check(ov_r && line_r == b, "R10 next out", line_r, b);
    @(posedge clk); @(negedge clk);
    check(!ov_r, "R10 empty", 256'(ov_r), 256'h0);
  endtask

  task automatic t_comb();
    @(negedge clk);
    in_valid = 1'b1; rdy_c = 1'b0; in_enc = 4'd2; in_payload = 256'h77;
    #1;
    check(ov_c && !in_ready_c, "R11 pass valid/ready", {in_ready_c, ov_c}, 256'h1);
    rdy_c = 1'b1; in_valid = 1'b0;
    #1;
    check(!ov_c && in_ready_c, "R11 pass valid/ready", {in_ready_c, ov_c}, 256'h2);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_raw(); t_zero(); t_repeat(); t_base8(); t_base4(); t_base2();
        t_wrap(); t_zero_base(); t_reserved(); t_stall(); t_comb();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule